// File: doc/BRIEF.md
# Scheduled Iterative Second-Order ODE Solver

This block integrates a second-order differential equation with forward-Euler steps in signed 32-bit integer arithmetic. Software or a neighbouring block presents the bound `a`, the step `dx` and the initial values of `x`, `u` and `y`, then pulses `start`. For as long as `x < a`, the block replaces x by x + dx, y by y + u·dx and u by u − 5·x·u·dx − 3·y·dx, always computing from the values of the previous step. When the test fails, the current `y` is returned with a single-cycle `done` pulse.

One step does not use a fully parallel combinational update. It runs on a small shared datapath made of two multipliers, one adder, one subtractor and one signed less-than comparator, under a fixed four-phase schedule. Multiplexers pick the operands of each unit in each phase, and registers carry partial products from one phase to the next.

| Phase | Multiplier 0 | Multiplier 1 | Adder | Subtractor | Comparator |
|---|---|---|---|---|---|
| C1 | u·dx | 5·x | x + dx | idle | x < a |
| C2 | (u·dx)·(5·x) | 3·y | idle | idle | idle |
| C3 | u·dx | dx·(3·y) | idle | u − 5xudx | idle |
| C4 | idle | idle | y + u·dx | diff − 3ydx | idle |

The controller has six states. IDLE goes to C1 on `start` and loads the operands. C1 goes to C2 when x < a and to FIN otherwise. C2 goes to C3. C3 goes to C4. C4 commits the step and goes to C1. FIN raises `done` and goes to IDLE.

Top module: `dsolve_top`

## Requirements
- R1: `start` is sampled only in IDLE, where it loads all five operands. A `start` seen in any other state has no effect on the running computation, its result or its latency.
- R2: Before each step the comparator tests x < a as signed numbers. The loop continues while this holds. When it fails (including x == a), the current y is the result.
- R3: Each step sets x := x + dx, u := u − 5·x·u·dx − 3·y·dx and y := y + u·dx from the old values. All arithmetic wraps modulo 2^32 and every product is truncated to 32 bits.
- R4: Each step takes exactly four cycles (C1, C2, C3, C4, then back to C1). For n steps, `done` is high 4·n + 2 clock edges after the edge that samples `start`, counting that edge as the first.
- R5: `done` is high for exactly one cycle and `y_out` carries the result while it is high. The block is then back in IDLE and accepts a new `start` on the next cycle.
- R6: If x ≥ a at start, the block finishes after the first C1 phase (`done` on the second edge) and returns the input y unchanged.
- R7: In every phase, each operand input of a unit that the schedule leaves unused is driven with 0.
- R8: After reset the block is in IDLE with `done` low and `y_out` zero.
- R9: The unit assignment per phase follows the schedule table, and x, u and y change only when operands are loaded or in phase C4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a solve; sampled in IDLE only |
| a_in | input | 32 | Signed upper bound on x |
| dx_in | input | 32 | Signed step size |
| x_in | input | 32 | Signed initial x |
| u_in | input | 32 | Signed initial u (first derivative) |
| y_in | input | 32 | Signed initial y |
| done | output | 1 | One-cycle result strobe |
| y_out | output | 32 | Signed result, valid while done is high |

## Verification
On every cycle, the assertions check the controller's transitions (C4 always returns to C1, C1 leaves for C2 or FIN by the comparison, FIN always returns to IDLE), that `done` never lasts two cycles, that idle units receive zero operands, and that x, u and y change only when the operands are loaded or in C4. Only the bench's scenarios can show that the step equations with 32-bit wrap-around give the right final y and that the latency is exactly 4·n + 2 cycles. They also show that a start while busy is ignored and that the x ≥ a and x == a boundaries return y unchanged.

// File: rtl/dsolve_pkg.sv
package dsolve_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_C1   = 3'd1,
        PH_C2   = 3'd2,
        PH_C3   = 3'd3,
        PH_C4   = 3'd4,
        PH_FIN  = 3'd5
    } phase_e;

    localparam int unsigned N_MUL   = 2;
    localparam int          K_XCOEF = 5;
    localparam int          K_YCOEF = 3;

endpackage

// File: rtl/dsolve_ctrl.sv
module dsolve_ctrl
    import dsolve_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   x_lt_a,
    output phase_e phase,
    output logic   load,
    output logic   done
);

    phase_e phase_q;
    phase_e phase_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start) phase_d = PH_C1;
            PH_C1:   phase_d = x_lt_a ? PH_C2 : PH_FIN;
            PH_C2:   phase_d = PH_C3;
            PH_C3:   phase_d = PH_C4;
            PH_C4:   phase_d = PH_C1;
            PH_FIN:  phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_comb begin
        phase = phase_q;
        load  = (phase_q == PH_IDLE) && start;
        done  = (phase_q == PH_FIN);
    end

    // R4: a committed step always re-enters the comparison phase
    a_r4_c4_to_c1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_C4) |=> (phase_q == PH_C1));

    // R2: comparison true keeps iterating
    a_r2_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_C1 && x_lt_a) |=> (phase_q == PH_C2));

    // R2/R6: comparison false finishes
    a_r6_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_C1 && !x_lt_a) |=> (phase_q == PH_FIN));

    // R5: done is a single-cycle strobe followed by idle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && phase_q == PH_IDLE));

    // R1: start outside idle does not disturb the C2 -> C3 progression
    a_r1_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_C2 && start) |=> (phase_q == PH_C3));

endmodule

// File: rtl/dsolve_units.sv
module dsolve_units #(
    parameter int unsigned W    = 32,
    parameter int unsigned NMUL = 2
) (
    input  logic [NMUL-1:0][W-1:0] mul_a,
    input  logic [NMUL-1:0][W-1:0] mul_b,
    input  logic [W-1:0]           add_a,
    input  logic [W-1:0]           add_b,
    input  logic [W-1:0]           sub_a,
    input  logic [W-1:0]           sub_b,
    input  logic [W-1:0]           cmp_a,
    input  logic [W-1:0]           cmp_b,
    output logic [NMUL-1:0][W-1:0] prod,
    output logic [W-1:0]           sum,
    output logic [W-1:0]           diff,
    output logic                   lt
);

    for (genvar gi = 0; gi < NMUL; gi++) begin : g_mul
        assign prod[gi] = mul_a[gi] * mul_b[gi];
    end

    assign sum  = add_a + add_b;
    assign diff = sub_a - sub_b;
    assign lt   = $signed(cmp_a) < $signed(cmp_b);

endmodule

// File: rtl/dsolve_datapath.sv
module dsolve_datapath
    import dsolve_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       phase,
    input  logic         load,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] dx_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] u_in,
    input  logic [W-1:0] y_in,
    output logic         x_lt_a,
    output logic [W-1:0] y_val
);

    localparam logic [W-1:0] XCOEF = W'(K_XCOEF);
    localparam logic [W-1:0] YCOEF = W'(K_YCOEF);

    logic [W-1:0] a_q, dx_q, x_q, u_q, y_q;
    logic [W-1:0] xn_q, pa_q, pb_q, d_q;

    logic [N_MUL-1:0][W-1:0] mul_a, mul_b, prod;
    logic [W-1:0] add_a, add_b, sub_a, sub_b, cmp_a, cmp_b;
    logic [W-1:0] sum, diff;
    logic         lt;

    always_comb begin
        mul_a = '0;
        mul_b = '0;
        add_a = '0;
        add_b = '0;
        sub_a = '0;
        sub_b = '0;
        cmp_a = '0;
        cmp_b = '0;
        unique case (phase)
            PH_C1: begin
                mul_a[0] = u_q;  mul_b[0] = dx_q;
                mul_a[1] = XCOEF; mul_b[1] = x_q;
                add_a    = x_q;  add_b    = dx_q;
                cmp_a    = x_q;  cmp_b    = a_q;
            end
            PH_C2: begin
                mul_a[0] = pa_q;  mul_b[0] = pb_q;
                mul_a[1] = YCOEF; mul_b[1] = y_q;
            end
            PH_C3: begin
                mul_a[0] = u_q;  mul_b[0] = dx_q;
                mul_a[1] = dx_q; mul_b[1] = pb_q;
                sub_a    = u_q;  sub_b    = pa_q;
            end
            PH_C4: begin
                add_a = y_q; add_b = pa_q;
                sub_a = d_q; sub_b = pb_q;
            end
            default: ;
        endcase
    end

    dsolve_units #(.W(W), .NMUL(N_MUL)) units_i (
        .mul_a (mul_a),
        .mul_b (mul_b),
        .add_a (add_a),
        .add_b (add_b),
        .sub_a (sub_a),
        .sub_b (sub_b),
        .cmp_a (cmp_a),
        .cmp_b (cmp_b),
        .prod  (prod),
        .sum   (sum),
        .diff  (diff),
        .lt    (lt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0; dx_q <= '0; x_q <= '0; u_q <= '0; y_q <= '0;
            xn_q <= '0; pa_q <= '0; pb_q <= '0; d_q <= '0;
        end else if (load) begin
            a_q  <= a_in;
            dx_q <= dx_in;
            x_q  <= x_in;
            u_q  <= u_in;
            y_q  <= y_in;
        end else begin
            unique case (phase)
                PH_C1: begin
                    pa_q <= prod[0];
                    pb_q <= prod[1];
                    xn_q <= sum;
                end
                PH_C2: begin
                    pa_q <= prod[0];
                    pb_q <= prod[1];
                end
                PH_C3: begin
                    pa_q <= prod[0];
                    pb_q <= prod[1];
                    d_q  <= diff;
                end
                PH_C4: begin
                    y_q <= sum;
                    u_q <= diff;
                    x_q <= xn_q;
                end
                default: ;
            endcase
        end
    end

    assign x_lt_a = lt;
    assign y_val  = y_q;

    // R7: the adder and subtractor sit idle in C2 and see zeros
    a_r7_c2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C2) |-> (add_a == '0 && add_b == '0 && sub_a == '0 && sub_b == '0));

    // R7: the multipliers sit idle in C4 and see zeros
    a_r7_c4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C4) |-> (mul_a == '0 && mul_b == '0 && cmp_a == '0));

    // R9: state values move only on load or at commit
    a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && phase != PH_C4) |=> ($stable(x_q) && $stable(u_q) && $stable(y_q)));

endmodule

// File: rtl/dsolve_top.sv
module dsolve_top
    import dsolve_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] dx_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] u_in,
    input  logic [W-1:0] y_in,
    output logic         done,
    output logic [W-1:0] y_out
);

    phase_e phase;
    logic   load;
    logic   x_lt_a;

    dsolve_ctrl ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .x_lt_a (x_lt_a),
        .phase  (phase),
        .load   (load),
        .done   (done)
    );

    dsolve_datapath #(.W(W)) dp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .load   (load),
        .a_in   (a_in),
        .dx_in  (dx_in),
        .x_in   (x_in),
        .u_in   (u_in),
        .y_in   (y_in),
        .x_lt_a (x_lt_a),
        .y_val  (y_out)
    );

endmodule

// File: tb/dsolve_top_tb_top.sv
module dsolve_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a_in = '0, dx_in = '0, x_in = '0, u_in = '0, y_in = '0;
    logic        done;
    logic [31:0] y_out;

    int checks = 0;
    int errors = 0;
    int exp_y[$];
    int exp_lat[$];
    int lat = 0;
    bit running = 1'b0;
    bit prev_done = 1'b0;
    longint cyc = 0;

    always #2.5 clk = ~clk;

    dsolve_top dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a_in  (a_in),
        .dx_in (dx_in),
        .x_in  (x_in),
        .u_in  (u_in),
        .y_in  (y_in),
        .done  (done),
        .y_out (y_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void model(input int a, input int dx, input int x0, input int u0,
                                  input int y0, output int yr, output int steps);
        int x = x0;
        int u = u0;
        int y = y0;
        int un;
        steps = 0;
        while (x < a && steps < 10000) begin
            un = u - 5 * x * u * dx - 3 * y * dx;
            y  = y + u * dx;
            u  = un;
            x  = x + dx;
            steps++;
        end
        yr = y;
    endfunction

    // driver: pushes expected items, then issues the job
    task automatic run(input int a, input int dx, input int x, input int u, input int y,
                       input bit poke_busy);
        int yr;
        int n;
        model(a, dx, x, u, y, yr, n);
        exp_y.push_back(yr);
        exp_lat.push_back(4 * n + 2);
        @(posedge clk); #1;
        a_in = a; dx_in = dx; x_in = x; u_in = u; y_in = y;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke_busy) begin
            // R1: a start while busy, with other operands, must be ignored
            repeat (3) @(posedge clk);
            #1;
            a_in = 7; dx_in = 1; x_in = 0; u_in = 9; y_in = 123;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (exp_y.size() != 0) @(posedge clk);
    endtask

    // monitor: pops and compares results as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (start && !running) begin
                lat = 0;
                running = 1'b1;
            end else begin
                lat++;
            end
            if (done) begin
                if (exp_y.size() == 0) begin
                    chk(1'b0, "R5 unexpected done", 1, 0);
                end else begin
                    int ey;
                    int el;
                    ey = exp_y.pop_front();
                    el = exp_lat.pop_front();
                    // R2/R3/R7: final y from the step equations
                    chk(y_out == ey, "R3 result", $signed(y_out), ey);
                    // R4/R6: latency of 4n+2 edges
                    chk(lat == el, "R4 latency", lat, el);
                end
                running = 1'b0;
            end
            if (done && prev_done) chk(1'b0, "R5 done longer than one cycle", 2, 1);
            prev_done = done;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(done == 1'b0, "R8 done low in reset", done, 0);
        chk(y_out == '0, "R8 y_out zero in reset", y_out, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R8 done low after reset", done, 0);

        run(10, 1, 0, 1, 0, 1'b0);                 // R3 ten steps
        run(5, 2, 0, 3, 7, 1'b0);                  // R3 step of two
        run(3, 1, 9, 4, -12, 1'b0);                // R6 x above a
        run(4, 1, 4, 2, 5, 1'b0);                  // R2 x equal to a
        run(-2, 1, -6, -3, 2, 1'b0);               // R2 signed compare
        run(3, 1, 0, 32'h4000_0000, 1000000, 1'b0); // R3 wrap-around
        run(20, 3, 0, 2, 1, 1'b1);                 // R1 start while busy
        run(2, 1, 1, 100, -50, 1'b0);              // R5 back-to-back accept
        run(50, 1, 0, -1, 3, 1'b0);                // R4 long run

        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R5 idle after last job", done, 0);
        finish_run();
    end

endmodule